// File: doc/BRIEF.md
# Timer Event Trigger Router

This block sits next to two general-purpose timers, called A and B. Each timer delivers three single-cycle event strobes: time-out, capture-match and match. The block routes these strobes to two destinations:

- A DMA request line for each timer.
- One shared ADC trigger line.

Each destination has its own software-programmed enable mask. All enabled events bound for the same destination in a cycle are merged into one pulse of one clock cycle.

The block also keeps a raw status bit for each event. These bits are set whether or not the event is enabled. The DMA engine returns a completion strobe for each timer, and that strobe sets its own status bit. Software clears status bits by writing 1 to them.

Software reaches the registers through a simple word bus. It has a valid strobe, a write flag, a word index and 32-bit write data. Read data is registered and appears one cycle after the read strobe.

Top module: `tmr_evt_router`

## Requirements
- R1: While and after reset, `dma_req` and `adc_trig` are low and all four registers read as zero.
- R2: Event bit layout. Bit 0 is timer A time-out, bit 1 A capture, bit 2 A match, bit 3 B time-out, bit 4 B capture, bit 5 B match. This layout is shared by the DMA mask (word 1), the ADC mask (word 2) and status bits [5:0] (word 3). An event whose DMA mask bit is 1 drives `dma_req[t]` high in the cycle after the strobe, where t is 0 for A and 1 for B.
- R3: Several enabled events of one timer in the same cycle give one `dma_req` pulse of exactly one cycle.
- R4: An event whose DMA and ADC mask bits are 0 produces no pulse, yet still sets its status bit.
- R5: `adc_trig` pulses in the cycle after any event that is enabled in the ADC mask and whose timer has its trigger enable set. Trigger enable is word 0, bit 0 for A and bit 1 for B. Events of both timers merge into one pulse of one cycle.
- R6: With a timer's trigger enable at 0, none of its events produces `adc_trig`, whatever the ADC mask holds.
- R7: `dma_done[0]` sets status bit 6 and `dma_done[1]` sets status bit 7, visible from the next cycle.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If a clear and a new set of the same bit fall in one cycle, the bit ends up set.
- R9: A read with `reg_valid`=1 and `reg_wr`=0 returns the register selected by `reg_addr` on `reg_rdata` after the next clock edge, in bits [7:0] with the upper bits zero.
- R10: The DMA and ADC masks act independently. An event enabled in only one of them pulses only that destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_tmo | input | 2 | Time-out strobes, [0]=A, [1]=B |
| evt_cap | input | 2 | Capture-match strobes |
| evt_mat | input | 2 | Match strobes |
| dma_done | input | 2 | DMA completion strobes per timer |
| reg_valid | input | 1 | Bus access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Word index: 0 trigger enable, 1 DMA mask, 2 ADC mask, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| dma_req | output | 2 | DMA request pulse per timer |
| adc_trig | output | 1 | ADC trigger pulse |

## Verification
Two functions can hit the same status bit in one cycle: a software write-1-to-clear and a hardware set, which can come from an event strobe or from a DMA completion. The bench forces this case. It drives a timer A time-out and a DMA-done in the same cycle as a status write that clears those very bits. A read afterwards must show them still set, while neighbouring bits cleared by the same write must read zero. The bench also fires events of one timer on multiple strobe lines in one cycle, to check that the output merges them into a single pulse.

// File: rtl/tmr_evt_router.sv
module tmr_evt_router #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    evt_tmo,
  input  logic [1:0]    evt_cap,
  input  logic [1:0]    evt_mat,
  input  logic [1:0]    dma_done,
  input  logic          reg_valid,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [1:0]    dma_req,
  output logic          adc_trig
);
  localparam int NEV = 6;
  localparam int NST = NEV + 2;

  logic [1:0]     trig_en;
  logic [NEV-1:0] dma_mask;
  logic [NEV-1:0] adc_mask;
  logic [NST-1:0] raw;
  logic [NST-1:0] rd_mux;

  wire [NEV-1:0] ev = {evt_mat[1], evt_cap[1], evt_tmo[1],
                       evt_mat[0], evt_cap[0], evt_tmo[0]};
  wire           wr_hit  = reg_valid & reg_wr;
  wire           rd_hit  = reg_valid & ~reg_wr;
  wire [NST-1:0] clr     = (wr_hit && reg_addr == 2'd3) ? reg_wdata[NST-1:0] : '0;
  wire [NEV-1:0] dma_hit = ev & dma_mask;
  wire [NEV-1:0] adc_hit = ev & adc_mask & {{3{trig_en[1]}}, {3{trig_en[0]}}};

  always_comb begin
    case (reg_addr)
      2'd0:    rd_mux = {{(NST-2){1'b0}}, trig_en};
      2'd1:    rd_mux = {2'b00, dma_mask};
      2'd2:    rd_mux = {2'b00, adc_mask};
      default: rd_mux = raw;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_en   <= '0;
      dma_mask  <= '0;
      adc_mask  <= '0;
      raw       <= '0;
      dma_req   <= '0;
      adc_trig  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (wr_hit) begin
        case (reg_addr)
          2'd0:    trig_en  <= reg_wdata[1:0];
          2'd1:    dma_mask <= reg_wdata[NEV-1:0];
          2'd2:    adc_mask <= reg_wdata[NEV-1:0];
          default: ;
        endcase
      end
      raw      <= (raw & ~clr) | {dma_done, ev};
      dma_req  <= {|dma_hit[5:3], |dma_hit[2:0]};
      adc_trig <= |adc_hit;
      if (rd_hit) reg_rdata <= {{(DW-NST){1'b0}}, rd_mux};
    end
  end

  AST_DMA_A_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req[0] |-> $past(|ev[2:0]));                      // R2
  AST_DMA_B_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req[1] |-> |raw[5:3]);                            // R4
  AST_ADC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> $past(|trig_en));                        // R6
  AST_DONE_A_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dma_done[0]) |-> raw[6]);                       // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt_tmo[0]) |-> raw[0]);                        // R8
endmodule

// File: tb/tmr_evt_router_tb.sv
module tmr_evt_router_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [1:0]  dma;
    logic        adc;
    logic        rd_chk;
    logic [31:0] rd;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  evt_tmo = '0, evt_cap = '0, evt_mat = '0, dma_done = '0;
  logic        reg_valid = 1'b0, reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  dma_req;
  logic        adc_trig;

  exp_t q[$];
  int   n_cmp = 0, n_err = 0;
  bit   summary_done = 0;

  logic [1:0] m_en = '0;
  logic [5:0] m_dma = '0, m_adc = '0;
  logic [7:0] m_raw = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_evt_router u_dut (
    .clk(clk), .rst_n(rst_n),
    .evt_tmo(evt_tmo), .evt_cap(evt_cap), .evt_mat(evt_mat), .dma_done(dma_done),
    .reg_valid(reg_valid), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_req(dma_req), .adc_trig(adc_trig)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ea/eb bits: [0] time-out, [1] capture, [2] match
  task automatic cyc(input logic [2:0] ea, input logic [2:0] eb, input logic [1:0] dn,
                     input logic v, input logic w, input logic [1:0] a,
                     input logic [31:0] d, input string tag);
    exp_t e;
    logic [7:0] clr;
    @(negedge clk);
    evt_tmo = {eb[0], ea[0]}; evt_cap = {eb[1], ea[1]}; evt_mat = {eb[2], ea[2]};
    dma_done = dn; reg_valid = v; reg_wr = w; reg_addr = a; reg_wdata = d;
    e.dma[0] = |(ea & m_dma[2:0]);
    e.dma[1] = |(eb & m_dma[5:3]);
    e.adc = (m_en[0] & |(ea & m_adc[2:0])) | (m_en[1] & |(eb & m_adc[5:3]));
    e.rd_chk = v & ~w;
    case (a)
      2'd0: e.rd = {30'd0, m_en};
      2'd1: e.rd = {26'd0, m_dma};
      2'd2: e.rd = {26'd0, m_adc};
      default: e.rd = {24'd0, m_raw};
    endcase
    e.tag = tag;
    q.push_back(e);
    clr = (v && w && a == 2'd3) ? d[7:0] : 8'd0;
    if (v && w) begin
      case (a)
        2'd0: m_en = d[1:0];
        2'd1: m_dma = d[5:0];
        2'd2: m_adc = d[5:0];
        default: ;
      endcase
    end
    m_raw = (m_raw & ~clr) | {dn, eb, ea};
  endtask

  task automatic idle(input string tag);
    cyc(3'b0, 3'b0, 2'b0, 1'b0, 1'b0, 2'd0, 32'd0, tag);
  endtask
  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
    cyc(3'b0, 3'b0, 2'b0, 1'b1, 1'b1, a, d, tag);
  endtask
  task automatic rd(input logic [1:0] a, input string tag);
    cyc(3'b0, 3'b0, 2'b0, 1'b1, 1'b0, a, 32'd0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check({e.tag, " dma_req"}, {30'd0, dma_req}, {30'd0, e.dma});
        check({e.tag, " adc_trig"}, {31'd0, adc_trig}, {31'd0, e.adc});
        if (e.rd_chk) check({e.tag, " reg_rdata"}, reg_rdata, e.rd);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!summary_done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset dma_req", {30'd0, dma_req}, 32'd0);
    check("R1 reset adc_trig", {31'd0, adc_trig}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) rd(i[1:0], "R1 R9 reset read");
    // DMA: A time-out only, B capture+match
    wr(2'd1, 32'h31, "R9 dma mask write");
    rd(2'd1, "R9 dma mask read");
    cyc(3'b001, 3'b0, 2'b0, 1'b0, 1'b0, 2'd0, 0, "R2 A tmo pulse");
    idle("R2 pulse ends");
    cyc(3'b010, 3'b0, 2'b0, 1'b0, 1'b0, 2'd0, 0, "R4 A cap masked");
    cyc(3'b0, 3'b111, 2'b0, 1'b0, 1'b0, 2'd0, 0, "R3 B triple event");
    idle("R3 single cycle");
    cyc(3'b001, 3'b0, 2'b0, 1'b0, 1'b0, 2'd0, 0, "R2 back to back 1");
    cyc(3'b001, 3'b0, 2'b0, 1'b0, 1'b0, 2'd0, 0, "R2 back to back 2");
    rd(2'd3, "R4 status after events");
    // W1C collision: clear all, with new A tmo and done A in same cycle
    cyc(3'b001, 3'b0, 2'b01, 1'b1, 1'b1, 2'd3, 32'hFF, "R8 clear vs set");
    rd(2'd3, "R8 set wins");
    wr(2'd3, 32'h41, "R8 clear rest");
    rd(2'd3, "R8 cleared");
    // ADC: A capture, B time-out
    wr(2'd2, 32'h0A, "R10 adc mask write");
    cyc(3'b010, 3'b0, 2'b0, 1'b0, 1'b0, 2'd0, 0, "R6 trig enable off");
    wr(2'd0, 32'h1, "R5 enable A");
    cyc(3'b010, 3'b0, 2'b0, 1'b0, 1'b0, 2'd0, 0, "R5 A cap adc");
    cyc(3'b0, 3'b001, 2'b0, 1'b0, 1'b0, 2'd0, 0, "R6 B disabled");
    wr(2'd0, 32'h3, "R5 enable both");
    cyc(3'b0, 3'b001, 2'b0, 1'b0, 1'b0, 2'd0, 0, "R5 B tmo adc");
    cyc(3'b010, 3'b001, 2'b0, 1'b0, 1'b0, 2'd0, 0, "R5 merged adc");
    idle("R5 single cycle");
    cyc(3'b001, 3'b010, 2'b0, 1'b0, 1'b0, 2'd0, 0, "R10 dma only");
    cyc(3'b010, 3'b100, 2'b0, 1'b0, 1'b0, 2'd0, 0, "R10 mixed dest");
    cyc(3'b100, 3'b0, 2'b0, 1'b0, 1'b0, 2'd0, 0, "R4 A mat none");
    rd(2'd0, "R9 trig enable read");
    rd(2'd2, "R9 adc mask read");
    cyc(3'b0, 3'b0, 2'b10, 1'b0, 1'b0, 2'd0, 0, "R7 done B");
    rd(2'd3, "R7 status done bits");
    wr(2'd3, 32'h0F, "R8 partial clear");
    rd(2'd3, "R8 partial result");
    idle("drain");
    wait (q.size() == 0);
    @(negedge clk);
    summary_done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule